// File: doc/BRIEF.md
# Display Data Channel EDID Slave with Buffer RAM

This block is a two-wire serial slave that lets a display host read identification bytes from a local buffer RAM, the way an EDID EEPROM would serve them. SCL and SDA are synchronised to the system clock and edge-detected. A device address is matched, and the received bytes drive a shared byte pointer. A write transaction loads the pointer from its first data byte and then stores the following bytes. A read, usually entered through a repeated start, streams bytes from the pointer until the host answers with NACK.

Each byte to send comes from one of two sources. In automatic mode it is fetched from RAM at the pointer, with no CPU work. In software-feed mode it is taken from a transmit data register, and an interrupt asks the CPU to refill that register while the byte shifts out. A small CPU register port exposes the control bits, the pointer, the transmit register and a data window into the RAM. Any access through the window, or by the serial side, advances the pointer. The pointer wraps inside a 128-byte or a 256-byte buffer.

The system clock must run at least 16 times faster than SCL.

Top module: `edid_ddc_slave`

## Requirements
- R1: After reset the control, pointer and transmit registers read 00h, `sda_oe` is low and `irq` is low.
- R2: The CPU register offsets are:
  - 0: control. Bit 0 selects the 256-byte buffer, bit 1 selects software feed, bit 2 selects masked address match, and bit 3 is the sticky underrun flag, cleared by writing 1. Bits 7:4 read 0.
  - 1: pointer.
  - 2: transmit data.
  - 3: buffer window.
  
  `cpu_rdata` shows the selected value in the cycle after `cpu_re`, and the pointer and transmit registers read back what was written.
- R3: Each CPU read or write of the window accesses RAM at the pointer, then advances the pointer by one.
- R4: With control bit 0 clear, the pointer wraps from 7Fh to 00h and its bit 7 is zero after every advance. With bit 0 set, it steps from 7Fh to 80h and wraps from FFh to 00h.
- R5: With control bit 2 clear, only the address bytes A0h (write) and A1h (read) are acknowledged. Any other address gets no ACK, and SDA is not driven for the rest of that transaction.
- R6: With control bit 2 set, any address byte whose upper nibble is Ah is acknowledged, whatever its bits 3:1 are. Other address bytes are not.
- R7: In a write transaction every byte is acknowledged. The first data byte loads the pointer, and each later byte is stored at the pointer, which then advances.
- R8: In automatic mode a read sends RAM bytes starting at the pointer, and the pointer advances once per byte started.
- R9: In software-feed mode each byte sent is the transmit register's value, and the pointer does not move. `irq` rises when a byte starts shifting and falls when the CPU writes the transmit register.
- R10: In software-feed mode, if the transmit register was not rewritten since the last byte started, the same value is sent again and control bit 3 becomes 1.
- R11: After the host NACKs a read byte the slave stops driving SDA, and a STOP condition returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_re | input | 1 | CPU register read strobe |
| cpu_addr | input | 2 | CPU register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, valid the cycle after `cpu_re` |
| irq | output | 1 | Software-feed refill request |

## Verification
The hardest case to reach is the refill race in software-feed mode. The CPU must write the transmit register while a byte is already shifting on the bus. Then, on a later byte, it must deliberately miss the deadline so that the underrun repeat appears.

The bench forks a CPU write into the middle of a serial read of several bytes. It then lets the next byte pass without a refill and checks three things: the repeated value, the sticky flag, and that the pointer has not moved. Pointer wrap across the 7Fh boundary is reached by loading the pointer over the bus and reading past the boundary.

// File: rtl/edid_ddc_pkg.sv
package edid_ddc_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_WAIT
  } ddc_state_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PTR  = 2'd1;
  localparam logic [1:0] REG_TXD  = 2'd2;
  localparam logic [1:0] REG_WIN  = 2'd3;

  localparam int CB_BIG   = 0;
  localparam int CB_SOFT  = 1;
  localparam int CB_MASK  = 2;
  localparam int CB_UNDER = 3;

endpackage

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] line_in;
  logic [1:0] line_s;
  logic [1:0] line_p;

  assign line_in = {sda_in, scl_in};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], line_in[g]};
      end
      assign line_s[g] = ff[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) line_p <= 2'b11;
    else     line_p <= line_s;
  end

  assign sda_s     = line_s[1];
  assign scl_rise  = line_s[0] & ~line_p[0];
  assign scl_fall  = ~line_s[0] & line_p[0];
  assign start_det = line_s[0] & line_p[0] & line_p[1] & ~line_s[1];
  assign stop_det  = line_s[0] & line_p[0] & ~line_p[1] & line_s[1];

endmodule

// File: rtl/ddc_buf_ram.sv
module ddc_buf_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ddc_serial_fsm.sv
module ddc_serial_fsm
  import edid_ddc_pkg::*;
#(
  parameter logic [3:0] DEV_HI = 4'hA,
  parameter logic [2:0] DEV_LO = 3'b000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              mask_mode,
  input  logic [BYTE_W-1:0] src_byte,
  output logic              ld_req,
  output logic              wr_stb,
  output logic              ptr_stb,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_drive
);

  ddc_state_t        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              first;
  logic [1:0]        pend;
  logic              addr_hit;

  assign addr_hit = (shreg[7:4] == DEV_HI) && (mask_mode || (shreg[3:1] == DEV_LO));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      first     <= 1'b0;
      pend      <= '0;
      ld_req    <= 1'b0;
      wr_stb    <= 1'b0;
      ptr_stb   <= 1'b0;
      rx_byte   <= '0;
      sda_drive <= 1'b0;
    end else begin
      ld_req  <= 1'b0;
      wr_stb  <= 1'b0;
      ptr_stb <= 1'b0;
      pend    <= {pend[0], 1'b0};
      if (stop_det) begin
        state     <= ST_IDLE;
        sda_drive <= 1'b0;
        pend      <= '0;
      end else if (start_det) begin
        state     <= ST_ADDR;
        bitcnt    <= '0;
        sda_drive <= 1'b0;
        pend      <= '0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (addr_hit) begin
                sda_drive <= 1'b1;
                state     <= ST_AACK;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_drive <= 1'b0;
              bitcnt    <= '0;
              if (shreg[0]) begin
                ld_req  <= 1'b1;
                pend[0] <= 1'b1;
                state   <= ST_RDAT;
              end else begin
                first <= 1'b1;
                state <= ST_WDAT;
              end
            end
          end
          ST_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              ptr_stb   <= first;
              wr_stb    <= ~first;
              rx_byte   <= shreg;
              first     <= 1'b0;
              sda_drive <= 1'b1;
              state     <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_drive <= 1'b0;
              bitcnt    <= '0;
              state     <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (pend[1]) begin
              shreg     <= src_byte;
              sda_drive <= ~src_byte[BYTE_W-1];
            end else if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_drive <= 1'b0;
                state     <= ST_RACK;
              end else begin
                shreg     <= {shreg[BYTE_W-2:0], 1'b1};
                sda_drive <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_WAIT;
            end else if (scl_fall) begin
              ld_req  <= 1'b1;
              pend[0] <= 1'b1;
              bitcnt  <= '0;
              state   <= ST_RDAT;
            end
          end
          default: begin
            sda_drive <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/edid_ddc_slave.sv
module edid_ddc_slave
  import edid_ddc_pkg::*;
#(
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_HI      = 4'hA,
  parameter logic [2:0] DEV_LO      = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       cpu_we,
  input  logic       cpu_re,
  input  logic [1:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       irq
);

  localparam logic [AW-1:0] FULL_MASK = '1;
  localparam logic [AW-1:0] HALF_MASK = FULL_MASK >> 1;

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ld_req, wr_stb, ptr_stb, sda_drive;
  logic [BYTE_W-1:0] rx_byte, src_byte, ram_q;

  logic              ctrl_big, ctrl_soft, ctrl_mask, ctrl_under;
  logic [BYTE_W-1:0] tx_q;
  logic              tx_fresh, irq_q;
  logic [AW-1:0]     ptr_q, ptr_mask, ptr_adv, ram_addr;
  logic [BYTE_W-1:0] reg_q;
  logic              win_q;

  logic ser_rd, ser_busy, cpu_win_wr, cpu_win_rd, cpu_ptr_wr, ptr_inc;
  logic ram_we, ram_re;
  logic [BYTE_W-1:0] ram_wdata;

  ddc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  ddc_serial_fsm #(.DEV_HI(DEV_HI), .DEV_LO(DEV_LO)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mask_mode (ctrl_mask),
    .src_byte  (src_byte),
    .ld_req    (ld_req),
    .wr_stb    (wr_stb),
    .ptr_stb   (ptr_stb),
    .rx_byte   (rx_byte),
    .sda_drive (sda_drive)
  );

  // serial side wins any same-cycle buffer or pointer contention
  assign ser_rd     = ld_req & ~ctrl_soft;
  assign ser_busy   = ser_rd | wr_stb | ptr_stb;
  assign cpu_win_wr = cpu_we & (cpu_addr == REG_WIN) & ~ser_busy;
  assign cpu_win_rd = cpu_re & (cpu_addr == REG_WIN) & ~ser_busy;
  assign cpu_ptr_wr = cpu_we & (cpu_addr == REG_PTR) & ~ser_busy;
  assign ptr_inc    = ser_rd | wr_stb | cpu_win_wr | cpu_win_rd;

  assign ptr_mask = ctrl_big ? FULL_MASK : HALF_MASK;
  assign ptr_adv  = (ptr_q + 1'b1) & ptr_mask;
  assign ram_addr = ptr_q & ptr_mask;

  always_ff @(posedge clk) begin
    if (rst)             ptr_q <= '0;
    else if (ptr_stb)    ptr_q <= AW'(rx_byte) & ptr_mask;
    else if (ptr_inc)    ptr_q <= ptr_adv;
    else if (cpu_ptr_wr) ptr_q <= AW'(cpu_wdata) & ptr_mask;
  end

  assign ram_we    = wr_stb | cpu_win_wr;
  assign ram_re    = ser_rd | cpu_win_rd;
  assign ram_wdata = wr_stb ? rx_byte : cpu_wdata;

  ddc_buf_ram #(.AW(AW), .DW(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_addr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_addr),
    .rdata (ram_q)
  );

  assign src_byte = ctrl_soft ? tx_q : ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_big   <= 1'b0;
      ctrl_soft  <= 1'b0;
      ctrl_mask  <= 1'b0;
      ctrl_under <= 1'b0;
      tx_q       <= '0;
      tx_fresh   <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (cpu_we && cpu_addr == REG_CTRL) begin
        ctrl_big  <= cpu_wdata[CB_BIG];
        ctrl_soft <= cpu_wdata[CB_SOFT];
        ctrl_mask <= cpu_wdata[CB_MASK];
        if (cpu_wdata[CB_UNDER]) ctrl_under <= 1'b0;
      end
      if (cpu_we && cpu_addr == REG_TXD) begin
        tx_q     <= cpu_wdata;
        tx_fresh <= 1'b1;
        irq_q    <= 1'b0;
      end
      if (ld_req && ctrl_soft) begin
        tx_fresh <= 1'b0;
        irq_q    <= 1'b1;
        if (!tx_fresh) ctrl_under <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
      win_q <= 1'b0;
    end else begin
      win_q <= cpu_win_rd;
      if (cpu_re) begin
        unique case (cpu_addr)
          REG_CTRL: reg_q <= {4'b0000, ctrl_under, ctrl_mask, ctrl_soft, ctrl_big};
          REG_PTR:  reg_q <= BYTE_W'(ptr_q);
          REG_TXD:  reg_q <= tx_q;
          default:  reg_q <= '0;
        endcase
      end
    end
  end

  assign cpu_rdata = win_q ? ram_q : reg_q;
  assign sda_oe    = sda_drive;
  assign irq       = irq_q;

endmodule

// File: rtl/edid_ddc_checker.sv
module edid_ddc_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          irq,
  input logic          cpu_we,
  input logic [1:0]    cpu_addr,
  input logic          stop_det,
  input logic          ld_req,
  input logic          ptr_inc,
  input logic          big,
  input logic [AW-1:0] ptr,
  input logic          under
);

  // R1: reset leaves the bus released and the interrupt low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sda_oe && !irq));

  // R11: a STOP always releases SDA
  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R9: a transmit register write drops the interrupt
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == 2'd2 && !ld_req) |=> !irq);

  // R4: in the small buffer an advance never leaves bit 7 set
  a_r4_small_wrap: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && !big) |=> (ptr[AW-1] == 1'b0));

  // R10: the underrun flag is only raised by a byte load
  a_r10_underrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(under) |-> $past(ld_req));

endmodule

bind edid_ddc_slave edid_ddc_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .irq      (irq),
  .cpu_we   (cpu_we),
  .cpu_addr (cpu_addr),
  .stop_det (stop_det),
  .ld_req   (ld_req),
  .ptr_inc  (ptr_inc),
  .big      (ctrl_big),
  .ptr      (ptr_q),
  .under    (ctrl_under)
);

// File: tb/tb_edid_ddc_slave.sv
module tb_edid_ddc_slave;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       m_low = 1'b0;
  logic       cpu_we = 1'b0;
  logic       cpu_re = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       sda_oe;
  logic       irq;
  wire        sda_line = !(sda_oe || m_low);

  int total = 0;
  int bad = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  always #10 clk = ~clk;

  edid_ddc_slave dut (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_m),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .cpu_we    (cpu_we),
    .cpu_re    (cpu_re),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .irq       (irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", r, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_re = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_re = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = !b; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic recv_byte(input logic ack_it);
    logic [7:0] v;
    logic x;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(x);
      v = {v[6:0], x};
    end
    act_q.push_back(v);
    put_bit(!ack_it);
  endtask

  task automatic expect_byte(input string r, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(r);
  endtask

  // monitor: compares serial bytes against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (act_q.size() > 0) begin
        logic [7:0] v;
        v = act_q.pop_front();
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL unexpected serial byte: actual %02h expected none", v);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (v !== e) begin
            bad++;
            $display("FAIL %s serial byte: actual %02h expected %02h", t, v, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic ack, b;

    tick(5);
    rst = 1'b0;
    tick(3);

    // R1 reset state
    cpu_rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    cpu_rd(2'd1, d); chk("R1 ptr", d, 8'h00);
    cpu_rd(2'd2, d); chk("R1 txd", d, 8'h00);
    chk("R1 sda_oe/irq", {6'b0, sda_oe, irq}, 8'h00);

    // R2 register map and readback
    cpu_wr(2'd1, 8'h35); cpu_rd(2'd1, d); chk("R2 ptr rw", d, 8'h35);
    cpu_wr(2'd2, 8'h5A); cpu_rd(2'd2, d); chk("R2 txd rw", d, 8'h5A);
    cpu_wr(2'd0, 8'hF0); cpu_rd(2'd0, d); chk("R2 ctrl upper bits", d, 8'h00);
    cpu_wr(2'd0, 8'h05); cpu_rd(2'd0, d); chk("R2 ctrl bits", d, 8'h05);
    cpu_wr(2'd0, 8'h00);

    // R3 window access
    cpu_wr(2'd1, 8'h10);
    cpu_wr(2'd3, 8'h11); cpu_wr(2'd3, 8'h22); cpu_wr(2'd3, 8'h33);
    cpu_rd(2'd1, d); chk("R3 ptr after writes", d, 8'h13);
    cpu_wr(2'd1, 8'h10);
    cpu_rd(2'd3, d); chk("R3 window read 0", d, 8'h11);
    cpu_rd(2'd3, d); chk("R3 window read 1", d, 8'h22);
    cpu_rd(2'd3, d); chk("R3 window read 2", d, 8'h33);
    cpu_rd(2'd1, d); chk("R3 ptr after reads", d, 8'h13);

    // R4 wrap via CPU
    cpu_wr(2'd1, 8'h7F); cpu_wr(2'd3, 8'h77);
    cpu_rd(2'd1, d); chk("R4 128 wrap", d, 8'h00);
    cpu_wr(2'd0, 8'h01);
    cpu_wr(2'd1, 8'h7F); cpu_wr(2'd3, 8'h78);
    cpu_rd(2'd1, d); chk("R4 256 step 7F", d, 8'h80);
    cpu_wr(2'd1, 8'hFF); cpu_wr(2'd3, 8'h99);
    cpu_rd(2'd1, d); chk("R4 256 wrap", d, 8'h00);
    cpu_wr(2'd0, 8'h00);

    // R7 serial write
    bus_start();
    send_byte(8'hA0, ack); chk("R5 A0 ack", {7'b0, ack}, 8'h01);
    send_byte(8'h20, ack); chk("R7 offset ack", {7'b0, ack}, 8'h01);
    send_byte(8'hC1, ack); chk("R7 data ack", {7'b0, ack}, 8'h01);
    send_byte(8'hC2, ack);
    send_byte(8'hC3, ack);
    bus_stop();
    tick(4);
    cpu_rd(2'd1, d); chk("R7 ptr after write", d, 8'h23);
    cpu_wr(2'd1, 8'h20);
    cpu_rd(2'd3, d); chk("R7 stored 0", d, 8'hC1);
    cpu_rd(2'd3, d); chk("R7 stored 1", d, 8'hC2);
    cpu_rd(2'd3, d); chk("R7 stored 2", d, 8'hC3);

    // R8 automatic read with repeated start, R11 NACK and STOP
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h20, ack);
    bus_start();
    send_byte(8'hA1, ack); chk("R5 A1 ack", {7'b0, ack}, 8'h01);
    expect_byte("R8 byte 0", 8'hC1);
    expect_byte("R8 byte 1", 8'hC2);
    expect_byte("R8 byte 2", 8'hC3);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    get_bit(b); chk("R11 released after NACK", {7'b0, b}, 8'h01);
    bus_stop();
    tick(4);
    chk("R11 idle after stop", {7'b0, sda_oe}, 8'h00);
    cpu_rd(2'd1, d); chk("R8 ptr after read", d, 8'h23);

    // R5 non-matching address
    bus_start();
    send_byte(8'hA2, ack); chk("R5 A2 no ack", {7'b0, ack}, 8'h00);
    send_byte(8'h00, ack); chk("R5 no drive after miss", {7'b0, ack}, 8'h00);
    bus_stop();
    tick(4);
    cpu_rd(2'd1, d); chk("R5 ptr untouched", d, 8'h23);

    // R6 masked match
    cpu_wr(2'd0, 8'h04);
    bus_start();
    send_byte(8'hA6, ack); chk("R6 A6 ack", {7'b0, ack}, 8'h01);
    send_byte(8'h40, ack);
    bus_stop();
    tick(4);
    cpu_rd(2'd1, d); chk("R6 ptr loaded", d, 8'h40);
    bus_start();
    send_byte(8'hB0, ack); chk("R6 B0 no ack", {7'b0, ack}, 8'h00);
    bus_stop();

    // R9 software feed, R10 underrun
    cpu_wr(2'd0, 8'h02);
    cpu_wr(2'd1, 8'h05);
    cpu_wr(2'd2, 8'h3C);
    bus_start();
    send_byte(8'hA1, ack);
    expect_byte("R9 fed byte 0", 8'h3C);
    expect_byte("R9 fed byte 1", 8'h4D);
    expect_byte("R10 repeated byte", 8'h4D);
    fork
      recv_byte(1'b1);
      begin
        tick(60);
        chk("R9 irq on load", {7'b0, irq}, 8'h01);
        cpu_wr(2'd2, 8'h4D);
        chk("R9 irq cleared", {7'b0, irq}, 8'h00);
      end
    join
    recv_byte(1'b1);
    recv_byte(1'b0);
    bus_stop();
    tick(4);
    chk("R9 irq pending", {7'b0, irq}, 8'h01);
    cpu_rd(2'd0, d); chk("R10 underrun flag", d, 8'h0A);
    cpu_rd(2'd1, d); chk("R9 ptr unchanged", d, 8'h05);
    cpu_wr(2'd0, 8'h0A);
    cpu_rd(2'd0, d); chk("R10 flag cleared", d, 8'h02);

    // R4 serial wrap across 7Fh in 128-byte mode
    cpu_wr(2'd0, 8'h00);
    cpu_wr(2'd1, 8'h00); cpu_wr(2'd3, 8'h5E);
    cpu_wr(2'd1, 8'h7E); cpu_wr(2'd3, 8'hA7); cpu_wr(2'd3, 8'hA8);
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h7E, ack);
    bus_start();
    send_byte(8'hA1, ack);
    expect_byte("R4 serial 7E", 8'hA7);
    expect_byte("R4 serial 7F", 8'hA8);
    expect_byte("R4 serial wrap 00", 8'h5E);
    recv_byte(1'b1);
    recv_byte(1'b1);
    recv_byte(1'b0);
    bus_stop();
    tick(4);
    cpu_rd(2'd1, d); chk("R4 ptr after serial wrap", d, 8'h01);

    tick(10);
    chk("R8 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule